// File: doc/BRIEF.md
# Digital fourth-order one-bit requantizer

This block takes the multi-level output code of an upstream oversampling converter, one code per sample strobe, and turns it into a one-bit stream. The in-band content is kept. The truncation error is pushed out of band by a fourth-order noise-shaping loop. The loop is a chain of four delaying accumulators. Each accumulator input receives the error between the input code and the fed-back level, weighted by a gain. The fourth state plus the input forms the final sum, and its sign is the output bit.

Every gain is built from one or two binary shifts, so the datapath has adders only and no multipliers. A small local feedback path runs from the fourth accumulator into the third. It moves a pair of noise-transfer zeros off zero frequency, so that the shaped noise has a notch inside the band.

The block runs at the rate of the code it receives and produces exactly one output bit per strobe. A decimation filter downstream recovers the audio signal from the bitstream.

Top module: `rq_top`

## Requirements
- R1: A synchronous reset clears all four accumulator states and the output bit to zero.
- R2: On each clock edge where `sample_en` is high, the block processes one sample and updates `bit_out` with that sample's decision. The new bit is visible from that edge onward.
- R3: While `sample_en` is low, `code_in` is ignored. The accumulator states and `bit_out` hold their values.
- R4: The state variables are scaled by 2^9 per code unit.
  - The final sum is the fourth state plus `code_in`·2^9.
  - The decision is 1 when this sum is ≥ 0 and 0 otherwise.
  - A decision of 1 feeds back +12 codes and a decision of 0 feeds back −12 codes.
  - Example: straight after reset, code 0 gives 1 and code −1 gives 0.
- R5: With err = code − fed-back level, every state updates from the previous values of all states:
  - s1 += err·2^-7
  - s2 += s1 + err·2^-4
  - s3 += s2 + err·(2^-2+2^-3) − r
  - s4 += s3 + err·(2^-1+2^-2)
  - Here r is the resonator term defined in R6.
- R6: The resonator term r subtracted at the third accumulator input is floor(s4 / 2^9). This term rounds toward minus infinity.
- R7: `code_in` is a 4-bit two's-complement code. Its legal range is −6 to +5, which gives 12 levels.
- R8: The accumulator widths are 16, 20, 22 and 24 bits. No state ever wraps for any sequence of legal codes, so the output matches an unbounded-precision evaluation of R4 to R6 bit for bit.
- R9: For a constant legal code, the average of the ±12 stream over 8192 samples lies within 1/8 code of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_en | input | 1 | Strobe: one input code is consumed in each cycle where this is high |
| code_in | input | 4 | Signed multi-level input code, legal range −6..+5 |
| bit_out | output | 1 | Requantized one-bit stream, 1 means +full scale |

## Verification
Every legal constant code is run after reset and compared bit for bit with an unbounded-precision recursion. The extreme codes −6 and +5 show whether any accumulator wraps. The mid codes expose errors in coefficient shifts and in the rounding of the resonator term.

A pseudo-random code sequence with an irregular strobe does two things. It separates correct sample counting from a design that advances on idle cycles, and it shows whether input changes leak through while the strobe is low.

Long constant-input runs check that the bitstream average tracks the input. This catches a wrong feedback sign or level that a short bit-exact run could miss.

// File: rtl/rq_pkg.sv
package rq_pkg;

  // common arithmetic width of the loop datapath
  localparam int SW = 32;

  typedef logic signed [SW-1:0] acc_t;

  // one binary-weighted term: value times 2^sh
  function automatic acc_t pow2_term(input acc_t v, input int sh);
    return v <<< sh;
  endfunction

  // scaled division by 2^sh rounding toward minus infinity
  function automatic acc_t floor_div_pow2(input acc_t v, input int sh);
    return v >>> sh;
  endfunction

  // fed-back level for a decision bit
  function automatic acc_t fb_level(input logic d, input int lvl);
    return d ? acc_t'(lvl) : -acc_t'(lvl);
  endfunction

endpackage

// File: rtl/rq_coeff.sv
module rq_coeff
  import rq_pkg::*;
#(
  parameter int FRAC = 9,
  parameter int SA   = 7,
  parameter int SB   = -1
) (
  input  acc_t err,
  output acc_t term
);

  // the coefficient is 2^-SA (+ 2^-SB), state scaled by 2^FRAC
  generate
    if (SB < 0) begin : g_single
      assign term = pow2_term(err, FRAC - SA);
    end else begin : g_pair
      assign term = pow2_term(err, FRAC - SA) + pow2_term(err, FRAC - SB);
    end
  endgenerate

endmodule

// File: rtl/rq_integrator.sv
module rq_integrator
  import rq_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  acc_t delta,
  output acc_t state
);

  logic signed [W-1:0] state_q;
  acc_t                sum_full;

  assign state    = acc_t'(state_q);
  assign sum_full = state + delta;

  always_ff @(posedge clk) begin
    if (rst)     state_q <= '0;
    else if (en) state_q <= sum_full[W-1:0];
  end

  // R1: a reset cycle leaves the state at zero
  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> state_q == '0);

  // R3: idle cycles leave the state untouched
  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(state_q));

  // R8: the update never leaves the register's range
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    en |-> (sum_full >= -(acc_t'(1) <<< (W-1)) && sum_full < (acc_t'(1) <<< (W-1))));

endmodule

// File: rtl/rq_quantizer.sv
module rq_quantizer
  import rq_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  acc_t sum_in,
  output logic decision,
  output logic bit_q
);

  assign decision = (sum_in >= 0);

  always_ff @(posedge clk) begin
    if (rst)     bit_q <= 1'b0;
    else if (en) bit_q <= decision;
  end

  // R1: output is cleared by reset
  assert_out_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> bit_q == 1'b0);

  // R3: output holds between strobes
  assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(bit_q));

endmodule

// File: rtl/rq_top.sv
module rq_top
  import rq_pkg::*;
#(
  parameter int IN_W      = 4,
  parameter int CODE_MIN  = -6,
  parameter int CODE_MAX  = 5,
  parameter int FB_LVL    = 12,
  parameter int FRAC      = 9,
  parameter int RES_SHIFT = 9,
  parameter int W1        = 16,
  parameter int W2        = 20,
  parameter int W3        = 22,
  parameter int W4        = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   sample_en,
  input  logic signed [IN_W-1:0] code_in,
  output logic                   bit_out
);

  localparam int NSTG = 4;
  localparam int SHIFT_A [NSTG] = '{7, 4, 2, 1};
  localparam int SHIFT_B [NSTG] = '{-1, -1, 3, 2};
  localparam int MAX_ERR  = FB_LVL + ((-CODE_MIN > CODE_MAX) ? -CODE_MIN : CODE_MAX);
  localparam int STEP1_MAX = MAX_ERR <<< (FRAC - 7);

  acc_t code_ext;
  acc_t fb_val;
  acc_t err;
  acc_t coef_term [NSTG];
  acc_t s1, s2, s3, s4;
  acc_t res_term;
  acc_t final_sum;
  logic decision;

  assign code_ext = {{(SW-IN_W){code_in[IN_W-1]}}, code_in};
  assign fb_val   = fb_level(decision, FB_LVL);
  assign err      = code_ext - fb_val;

  genvar g;
  generate
    for (g = 0; g < NSTG; g++) begin : g_coef
      rq_coeff #(.FRAC(FRAC), .SA(SHIFT_A[g]), .SB(SHIFT_B[g])) u_coef (
        .err  (err),
        .term (coef_term[g])
      );
    end
  endgenerate

  // local resonator feedback from the last state into the third stage
  assign res_term  = floor_div_pow2(s4, RES_SHIFT);
  assign final_sum = s4 + pow2_term(code_ext, FRAC);

  rq_integrator #(.W(W1)) u_int1 (
    .clk(clk), .rst(rst), .en(sample_en),
    .delta(coef_term[0]), .state(s1)
  );

  rq_integrator #(.W(W2)) u_int2 (
    .clk(clk), .rst(rst), .en(sample_en),
    .delta(s1 + coef_term[1]), .state(s2)
  );

  rq_integrator #(.W(W3)) u_int3 (
    .clk(clk), .rst(rst), .en(sample_en),
    .delta(s2 + coef_term[2] - res_term), .state(s3)
  );

  rq_integrator #(.W(W4)) u_int4 (
    .clk(clk), .rst(rst), .en(sample_en),
    .delta(s3 + coef_term[3]), .state(s4)
  );

  rq_quantizer u_quant (
    .clk(clk), .rst(rst), .en(sample_en),
    .sum_in(final_sum), .decision(decision), .bit_q(bit_out)
  );

  // R7: only legal codes are presented with the strobe
  assert_code_legal_R7: assert property (@(posedge clk) disable iff (rst)
    sample_en |-> (code_ext >= CODE_MIN && code_ext <= CODE_MAX));

  // R5: the first state moves by at most the largest weighted error per sample
  assert_step_bound_R5: assert property (@(posedge clk) disable iff (rst)
    sample_en |=> ((s1 - $past(s1)) <= STEP1_MAX && (s1 - $past(s1)) >= -STEP1_MAX));

endmodule

// File: tb/test_rq_top.sv
`timescale 1ns/1ps
module test_rq_top;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sample_en = 1'b0;
  logic signed [3:0] code_in = '0;
  logic              bit_out;

  int errors = 0;
  int checks = 0;
  longint m1, m2, m3, m4;

  always #4 clk = ~clk;

  rq_top i_rq_top (
    .clk(clk), .rst(rst), .sample_en(sample_en),
    .code_in(code_in), .bit_out(bit_out)
  );

  task automatic summary_and_end();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: actual=timeout expected=completion");
    summary_and_end();
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // floor(v / 512) written as integer arithmetic
  function automatic longint floor512(input longint v);
    if (v >= 0) return v / 512;
    return -((-v + 511) / 512);
  endfunction

  task automatic model_clear();
    m1 = 0; m2 = 0; m3 = 0; m4 = 0;
  endtask

  // unbounded evaluation of the loop recursion (R4, R5, R6)
  task automatic model_step(input int u, output bit d);
    longint y, v, e, r, n1, n2, n3, n4;
    y  = m4 + longint'(u) * 512;
    d  = (y >= 0);
    v  = d ? 12 : -12;
    e  = u - v;
    r  = floor512(m4);
    n1 = m1 + 4 * e;
    n2 = m2 + m1 + 32 * e;
    n3 = m3 + m2 + 192 * e - r;
    n4 = m4 + m3 + 384 * e;
    m1 = n1; m2 = n2; m3 = n3; m4 = n4;
  endtask

  task automatic apply(input int u, input bit e, output bit got);
    @(negedge clk);
    code_in   = 4'(u);
    sample_en = e;
    @(posedge clk);
    #2 got = bit_out;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    sample_en = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  // R5 / R6 / R8: bit-exact constant-code run from reset
  task automatic run_dc_exact(input int u, input int n);
    int  bad = 0;
    bit  got, exp;
    longint first_act = 0, first_exp = 0;
    do_reset();
    for (int k = 0; k < n; k++) begin
      model_step(u, exp);
      apply(u, 1'b1, got);
      if (got !== exp && bad == 0) begin first_act = got; first_exp = exp; end
      if (got !== exp) bad++;
    end
    check(bad == 0, $sformatf("R5 R6 R8 dc code %0d bit mismatch", u), first_act, first_exp);
  endtask

  // R9: long-run average of the bitstream
  task automatic run_dc_average(input int u);
    int  ones = 0;
    bit  got;
    longint dev;
    do_reset();
    for (int k = 0; k < 8192; k++) begin
      apply(u, 1'b1, got);
      ones += got;
    end
    dev = 12 * (2 * longint'(ones) - 8192) - 8192 * longint'(u);
    if (dev < 0) dev = -dev;
    check(dev <= 1024, $sformatf("R9 dc average code %0d deviation", u), dev, 1024);
  endtask

  initial begin
    bit got, exp, prev;
    int bad_exact, bad_hold, strobes;
    logic [15:0] lfsr;

    // R1: reset state
    do_reset();
    #1;
    check(bit_out === 1'b0, "R1 output after reset", bit_out, 0);

    // R4: first decision from cleared state
    apply(0, 1'b1, got);
    check(got === 1'b1, "R4 code 0 from reset", got, 1);
    do_reset();
    apply(-1, 1'b1, got);
    check(got === 1'b0, "R4 code -1 from reset", got, 0);
    do_reset();
    apply(5, 1'b1, got);
    check(got === 1'b1, "R4 R7 code +5 from reset", got, 1);

    // R7 / R8: every legal code, bit-exact
    for (int u = -6; u <= 5; u++) run_dc_exact(u, 300);

    // R2 / R3: pseudo-random codes with irregular strobe
    do_reset();
    lfsr = 16'hACE1;
    bad_exact = 0; bad_hold = 0; strobes = 0; prev = 1'b0;
    for (int k = 0; k < 4000; k++) begin
      int  u;
      bit  e;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      u = int'(lfsr[7:0] % 12) - 6;
      e = (lfsr[9:8] != 2'b00);
      if (e) begin
        model_step(u, exp);
        strobes++;
        apply(u, 1'b1, got);
        if (got !== exp) bad_exact++;
      end else begin
        apply(u, 1'b0, got);
        if (got !== prev) bad_hold++;
      end
      prev = got;
    end
    check(bad_exact == 0, "R2 R5 R6 irregular strobe mismatches", bad_exact, 0);
    check(bad_hold == 0, "R3 output moved while idle", bad_hold, 0);
    check(strobes > 2000, "R2 strobe count exercised", strobes, 2000);

    // R1: mid-run reset returns to the cleared state
    do_reset();
    bad_exact = 0;
    for (int k = 0; k < 64; k++) begin
      model_step(2, exp);
      apply(2, 1'b1, got);
      if (got !== exp) bad_exact++;
    end
    check(bad_exact == 0, "R1 R5 sequence after second reset", bad_exact, 0);

    // R9: averages
    run_dc_average(-6);
    run_dc_average(-2);
    run_dc_average(0);
    run_dc_average(3);
    run_dc_average(5);

    summary_and_end();
  end

endmodule